// File: doc/BRIEF.md
# Task-Switch Segment Descriptor Validator

This block checks the seven selectors that a hardware task switch loads into the new context. The seven entries are, in this fixed order: the local descriptor table selector (slot 0), the code segment (slot 1), the stack segment (slot 2), and four data segments (slots 3 to 6). For each slot the caller supplies the raw 16-bit selector, a flag saying whether the descriptor fetch succeeded, and the decoded descriptor fields. For the table slot it also supplies one limit value. The block walks the slots one per clock cycle and stops at the first violation. It then returns a fault kind and an error code. If no slot fails, it returns a mask of the descriptor caches that may be marked valid.

A run begins with a one-cycle `start_i` while the block is idle. The caller holds every descriptor input steady until `done_o` pulses. The result stays on the outputs until the next accepted start. Fetching descriptors from memory, and the reduced loading used in the 8086-compatible mode, are left to the surrounding logic.

Top module: `task_seg_validator`

## Requirements
- R1: After reset, `done_o` is low, `fault_o` is 0, `err_code_o` is 0 and `cache_ok_o` is 0.
- R2: `start_i` is accepted only while idle. A start during a run has no effect: no extra `done_o`, and the result and latency are unchanged.
- R3: Slots are checked one per cycle in order 0..6. `done_o` is a one-cycle pulse, i+1 cycles after the accepting edge when slot i fails, or 7 cycles when all pass. `fault_o` encodes 0 = none, 1 = task-state fault, 2 = not-present fault, 3 = stack fault.
- R4: A selector is null when `sel & 0xFFFC == 0`. A null selector in slot 0 or slots 3..6 passes with its cache bit left clear. A null selector in slot 1 or slot 2 gives fault 1.
- R5: Slot 0 gives fault 1 in any of these cases:
  - selector bit 2 is set;
  - the descriptor is invalid;
  - the S bit (`code_data_i`) is 1;
  - the type is not 2;
  - `ldt_limit_i` is below 7;
  - the descriptor is not present.
- R6: Slot 1 needs a valid code/data descriptor with type bit 3 set (executable), else fault 1. When type bit 2 (conforming) is clear, the DPL must equal the selector RPL (`sel[1:0]`). When bit 2 is set, the DPL must not exceed the RPL. Either privilege violation gives fault 1. If all of these pass and the descriptor is not present, the fault is 2.
- R7: Slot 2 needs a valid code/data descriptor with type bit 3 clear and bit 1 (writable) set, else fault 1. If that passes and the descriptor is not present, the fault is 3, and this is tested before privilege. The DPL must then equal both the slot 1 RPL and its own RPL, else fault 1.
- R8: Slots 3..6 need a valid code/data descriptor that is not executable-without-read (type bit 3 set with bit 1 clear), else fault 1. When the type is below 12, the DPL must be at least the slot 1 RPL and at least its own RPL, else fault 1. If all of these pass and the descriptor is not present, the fault is 2.
- R9: A failed fetch (`fetch_ok_i` low) on a non-null selector gives fault 1 in every slot.
- R10: On a fault, `err_code_o` is the failing selector ANDed with 0xFFFC, and the first failing slot wins. With no fault, `err_code_o` is 0.
- R11: An accepted start clears `cache_ok_o`. Bit i is set only when slot i is non-null and passes. The failing slot and all later slots stay clear.
- R12: `fault_o`, `err_code_o` and `cache_ok_o` hold their values from the end of a run until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a validation run (taken only while idle) |
| sel_i | input | 112 | Raw selectors, slot k at bits [16k+15:16k] |
| fetch_ok_i | input | 7 | Descriptor fetch succeeded, one bit per slot |
| dvalid_i | input | 7 | Decoded descriptor is valid |
| code_data_i | input | 7 | S bit: 1 = code/data descriptor, 0 = system descriptor |
| type_i | input | 28 | 4-bit type per slot, slot k at bits [4k+3:4k] |
| dpl_i | input | 14 | 2-bit DPL per slot |
| present_i | input | 7 | Present bit per slot |
| ldt_limit_i | input | 20 | Limit of the slot 0 descriptor |
| done_o | output | 1 | One-cycle pulse when a run ends |
| fault_o | output | 2 | Fault kind (R3 encoding) |
| err_code_o | output | 16 | Error code of the first failing selector |
| cache_ok_o | output | 7 | Caches that may be marked valid |

## Verification
Some properties are checked on every cycle. `done_o` is always a single-cycle pulse that closes a run. Error codes are always aligned, and a clean run reports a zero code. A clean run always has the code and stack caches set. The mask is cleared on start, and the outputs are held while idle. The bench scenarios cover the rest. They show that each slot applies its own rule set and fault class, including the conforming privilege rule, the stack check that tests presence before privilege, and the treatment of null selectors. They also show that the first failure masks later slots, and the exact latency for each failing position.

// File: rtl/tsv_pkg.sv
package tsv_pkg;
    localparam int NSEG   = 7;
    localparam int SEL_W  = 16;
    localparam int TYPE_W = 4;
    localparam int DPL_W  = 2;
    localparam int IDX_W  = $clog2(NSEG);

    localparam int SLOT_TABLE = 0;
    localparam int SLOT_CODE  = 1;
    localparam int SLOT_STACK = 2;

    localparam logic [SEL_W-1:0] CODE_MASK = 16'hFFFC;

    typedef enum logic [1:0] {
        FK_NONE   = 2'd0,
        FK_TASK   = 2'd1,
        FK_ABSENT = 2'd2,
        FK_STACK  = 2'd3
    } fault_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic              fetch_ok;
        logic              dvalid;
        logic              code_data;
        logic              present;
        logic [TYPE_W-1:0] typ;
        logic [DPL_W-1:0]  dpl;
    } seg_entry_t;
endpackage

// File: rtl/tsv_pick.sv
module tsv_pick
    import tsv_pkg::*;
(
    input  logic [NSEG*SEL_W-1:0]  sel_i,
    input  logic [NSEG-1:0]        fetch_ok_i,
    input  logic [NSEG-1:0]        dvalid_i,
    input  logic [NSEG-1:0]        code_data_i,
    input  logic [NSEG*TYPE_W-1:0] type_i,
    input  logic [NSEG*DPL_W-1:0]  dpl_i,
    input  logic [NSEG-1:0]        present_i,
    input  logic [IDX_W-1:0]       idx_i,
    output seg_entry_t             entry_o
);
    seg_entry_t slots [NSEG];

    for (genvar k = 0; k < NSEG; k++) begin : g_slot
        assign slots[k].sel       = sel_i[k*SEL_W +: SEL_W];
        assign slots[k].fetch_ok  = fetch_ok_i[k];
        assign slots[k].dvalid    = dvalid_i[k];
        assign slots[k].code_data = code_data_i[k];
        assign slots[k].present   = present_i[k];
        assign slots[k].typ       = type_i[k*TYPE_W +: TYPE_W];
        assign slots[k].dpl       = dpl_i[k*DPL_W +: DPL_W];
    end

    always_comb begin
        entry_o = slots[0];
        for (int k = 1; k < NSEG; k++) begin
            if (idx_i == IDX_W'(k)) entry_o = slots[k];
        end
    end
endmodule

// File: rtl/tsv_rule.sv
module tsv_rule
    import tsv_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    input  seg_entry_t       entry_i,
    input  logic [DPL_W-1:0] code_rpl_i,
    input  logic             table_lim_ok_i,
    output fault_e           kind_o,
    output logic             is_null_o
);
    logic [DPL_W-1:0] rpl;
    logic             exec_b, conf_b, rw_b;

    assign rpl       = entry_i.sel[DPL_W-1:0];
    assign exec_b    = entry_i.typ[3];
    assign conf_b    = entry_i.typ[2];
    assign rw_b      = entry_i.typ[1];
    assign is_null_o = (entry_i.sel & CODE_MASK) == '0;

    always_comb begin
        kind_o = FK_NONE;
        if (idx_i == IDX_W'(SLOT_TABLE)) begin
            if (entry_i.sel[2])
                kind_o = FK_TASK;
            else if (is_null_o)
                kind_o = FK_NONE;
            else if (!entry_i.fetch_ok || !entry_i.dvalid || entry_i.code_data ||
                     entry_i.typ != TYPE_W'(2) || !table_lim_ok_i || !entry_i.present)
                kind_o = FK_TASK;
        end else if (is_null_o) begin
            if (idx_i == IDX_W'(SLOT_CODE) || idx_i == IDX_W'(SLOT_STACK))
                kind_o = FK_TASK;
        end else if (!entry_i.fetch_ok) begin
            kind_o = FK_TASK;
        end else if (idx_i == IDX_W'(SLOT_CODE)) begin
            if (!entry_i.dvalid || !entry_i.code_data || !exec_b)
                kind_o = FK_TASK;
            else if (!conf_b && entry_i.dpl != rpl)
                kind_o = FK_TASK;
            else if (conf_b && entry_i.dpl > rpl)
                kind_o = FK_TASK;
            else if (!entry_i.present)
                kind_o = FK_ABSENT;
        end else if (idx_i == IDX_W'(SLOT_STACK)) begin
            if (!entry_i.dvalid || !entry_i.code_data || exec_b || !rw_b)
                kind_o = FK_TASK;
            else if (!entry_i.present)
                kind_o = FK_STACK;
            else if (entry_i.dpl != code_rpl_i || entry_i.dpl != rpl)
                kind_o = FK_TASK;
        end else begin
            if (!entry_i.dvalid || !entry_i.code_data || (exec_b && !rw_b))
                kind_o = FK_TASK;
            else if (!(exec_b && conf_b) &&
                     (entry_i.dpl < code_rpl_i || entry_i.dpl < rpl))
                kind_o = FK_TASK;
            else if (!entry_i.present)
                kind_o = FK_ABSENT;
        end
    end
endmodule

// File: rtl/task_seg_validator.sv
module task_seg_validator
    import tsv_pkg::*;
#(
    parameter int LIM_W         = 20,
    parameter int MIN_TABLE_LIM = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [NSEG*SEL_W-1:0]  sel_i,
    input  logic [NSEG-1:0]        fetch_ok_i,
    input  logic [NSEG-1:0]        dvalid_i,
    input  logic [NSEG-1:0]        code_data_i,
    input  logic [NSEG*TYPE_W-1:0] type_i,
    input  logic [NSEG*DPL_W-1:0]  dpl_i,
    input  logic [NSEG-1:0]        present_i,
    input  logic [LIM_W-1:0]       ldt_limit_i,
    output logic                   done_o,
    output logic [1:0]             fault_o,
    output logic [SEL_W-1:0]       err_code_o,
    output logic [NSEG-1:0]        cache_ok_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSEG - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic             done;
        fault_e           fault;
        logic [SEL_W-1:0] err;
        logic [NSEG-1:0]  cache;
    } state_t;

    state_t     st_d, st_q;
    seg_entry_t cur_entry;
    fault_e     cur_kind;
    logic       cur_null;
    logic       lim_ok;
    logic       run_w;

    assign lim_ok = ldt_limit_i >= LIM_W'(MIN_TABLE_LIM);
    assign run_w  = st_q.busy;

    tsv_pick u_pick (
        .sel_i       (sel_i),
        .fetch_ok_i  (fetch_ok_i),
        .dvalid_i    (dvalid_i),
        .code_data_i (code_data_i),
        .type_i      (type_i),
        .dpl_i       (dpl_i),
        .present_i   (present_i),
        .idx_i       (st_q.idx),
        .entry_o     (cur_entry)
    );

    tsv_rule u_rule (
        .idx_i          (st_q.idx),
        .entry_i        (cur_entry),
        .code_rpl_i     (sel_i[SLOT_CODE*SEL_W +: DPL_W]),
        .table_lim_ok_i (lim_ok),
        .kind_o         (cur_kind),
        .is_null_o      (cur_null)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.idx   = '0;
                st_d.fault = FK_NONE;
                st_d.err   = '0;
                st_d.cache = '0;
            end
        end else if (cur_kind != FK_NONE) begin
            st_d.busy  = 1'b0;
            st_d.done  = 1'b1;
            st_d.fault = cur_kind;
            st_d.err   = cur_entry.sel & CODE_MASK;
        end else begin
            if (!cur_null) st_d.cache[st_q.idx] = 1'b1;
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, idx: '0, done: 1'b0, fault: FK_NONE,
                      err: '0, cache: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o     = st_q.done;
    assign fault_o    = st_q.fault;
    assign err_code_o = st_q.err;
    assign cache_ok_o = st_q.cache;
endmodule

// File: rtl/tsv_chk.sv
module tsv_chk
    import tsv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy,
    input logic             done_o,
    input logic [1:0]       fault_o,
    input logic [SEL_W-1:0] err_code_o,
    input logic [NSEG-1:0]  cache_ok_o
);
    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy));

    // R10
    err_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> err_code_o[1:0] == 2'b00);

    // R10
    clean_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o == 2'd0) |-> err_code_o == '0);

    // R4
    core_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o == 2'd0) |-> (cache_ok_o[SLOT_CODE] && cache_ok_o[SLOT_STACK]));

    // R11
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_i) |=> cache_ok_o == '0);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i) |=> ($stable(fault_o) && $stable(err_code_o) && $stable(cache_ok_o)));
endmodule

bind task_seg_validator tsv_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy       (run_w),
    .done_o     (done_o),
    .fault_o    (fault_o),
    .err_code_o (err_code_o),
    .cache_ok_o (cache_ok_o)
);

// File: tb/tb_task_seg_validator.sv
module tb_task_seg_validator;
    localparam int N = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [N*16-1:0] sel_f;
    logic [N-1:0]    fok, dval, cd, pres;
    logic [N*4-1:0]  typ_f;
    logic [N*2-1:0]  dpl_f;
    logic [19:0]     lim;
    logic            done_o;
    logic [1:0]      fault_o;
    logic [15:0]     err_code_o;
    logic [N-1:0]    cache_ok_o;

    logic [15:0] b_sel [N];
    logic [3:0]  b_typ [N];
    logic [1:0]  b_dpl [N];

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int k = 0; k < N; k++) begin
            sel_f[k*16 +: 16] = b_sel[k];
            typ_f[k*4 +: 4]   = b_typ[k];
            dpl_f[k*2 +: 2]   = b_dpl[k];
        end
    end

    task_seg_validator dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_f),
        .fetch_ok_i(fok), .dvalid_i(dval), .code_data_i(cd), .type_i(typ_f),
        .dpl_i(dpl_f), .present_i(pres), .ldt_limit_i(lim), .done_o(done_o),
        .fault_o(fault_o), .err_code_o(err_code_o), .cache_ok_o(cache_ok_o)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog act=%0d exp<150000 cycles", cycles);
            summary();
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_kind(int k, logic [1:0] crpl);
        logic [15:0] s = b_sel[k];
        logic [3:0]  t = b_typ[k];
        logic [1:0]  dp = b_dpl[k];
        logic nul = (s & 16'hFFFC) == 0;
        if (k == 0) begin
            if (s[2]) return 2'd1;
            if (nul) return 2'd0;
            if (!fok[0] || !dval[0] || cd[0] || t != 4'd2 || lim < 20'd7 || !pres[0]) return 2'd1;
            return 2'd0;
        end
        if (nul) return (k == 1 || k == 2) ? 2'd1 : 2'd0;
        if (!fok[k]) return 2'd1;
        if (k == 1) begin
            if (!dval[k] || !cd[k] || !t[3]) return 2'd1;
            if (!t[2] && dp != s[1:0]) return 2'd1;
            if (t[2] && dp > s[1:0]) return 2'd1;
            if (!pres[k]) return 2'd2;
            return 2'd0;
        end
        if (k == 2) begin
            if (!dval[k] || !cd[k] || t[3] || !t[1]) return 2'd1;
            if (!pres[k]) return 2'd3;
            if (dp != crpl || dp != s[1:0]) return 2'd1;
            return 2'd0;
        end
        if (!dval[k] || !cd[k] || (t[3] && !t[1])) return 2'd1;
        if (t < 4'd12 && (dp < crpl || dp < s[1:0])) return 2'd1;
        if (!pres[k]) return 2'd2;
        return 2'd0;
    endfunction

    task automatic load_good();
        logic [1:0] r = 2'($urandom_range(0, 3));
        for (int k = 0; k < N; k++) begin
            fok[k] = 1; dval[k] = 1; cd[k] = 1; pres[k] = 1;
            b_sel[k] = {13'($urandom_range(1, 8000)), 1'b0, 2'($urandom_range(0, 3))};
            b_typ[k] = 4'b0010; b_dpl[k] = 2'd3;
        end
        cd[0] = 0; b_typ[0] = 4'd2; lim = 20'($urandom_range(7, 5000));
        b_sel[1][1:0] = r; b_typ[1] = 4'b1010; b_dpl[1] = r;
        b_sel[2][1:0] = r; b_dpl[2] = r;
    endtask

    // Runs one validation; mid_start pulses start_i during the run (R2).
    task automatic run(string tag, bit mid_start);
        logic [1:0] ek = 0;
        logic [15:0] ee = 0;
        logic [N-1:0] em = 0;
        int elat = N;
        int lat = 0;
        for (int k = 0; k < N; k++) begin
            ek = ref_kind(k, b_sel[1][1:0]);
            if (ek != 0) begin ee = b_sel[k] & 16'hFFFC; elat = k + 1; break; end
            if ((b_sel[k] & 16'hFFFC) != 0) em[k] = 1;
        end
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = mid_start;
        do begin
            @(negedge clk); start_i = 0; lat++;
        end while (!done_o && lat < 20);
        chk({tag, " R3 latency"}, lat, elat);
        chk({tag, " R3 fault"}, fault_o, ek);
        chk({tag, " R10 errcode"}, err_code_o, ee);
        chk({tag, " R11 cache"}, cache_ok_o, em);
        @(negedge clk);
        chk({tag, " R3 done pulse"}, done_o, 0);
        @(negedge clk);
        chk({tag, " R12 hold"}, {fault_o, err_code_o, cache_ok_o}, {ek, ee, em});
    endtask

    initial begin
        void'($urandom(32'd4242));
        load_good();
        repeat (3) @(negedge clk);
        chk("R1 done", done_o, 0);
        chk("R1 fault", fault_o, 0);
        chk("R1 err", err_code_o, 0);
        chk("R1 cache", cache_ok_o, 0);
        rst_n = 1;

        load_good(); run("R3 all pass", 0);
        load_good(); b_sel[1] = 16'h0003; run("R4 null code", 0);
        load_good(); b_sel[2] = 16'h0002; run("R4 null stack", 0);
        load_good(); b_sel[3] = 16'h0001; b_sel[6] = 0; b_sel[0] = 0; run("R4 null data/table", 0);
        load_good(); b_sel[0][2] = 1; run("R5 table TI", 0);
        load_good(); lim = 20'd6; run("R5 table limit", 0);
        load_good(); pres[0] = 0; run("R5 table absent", 0);
        load_good(); b_typ[1] = 4'b1110; b_sel[1][1:0] = 2'd2; b_sel[2][1:0] = 2'd2;
        b_dpl[2] = 2'd2; b_dpl[1] = 2'd1; run("R6 conforming low dpl", 0);
        load_good(); b_typ[1] = 4'b1110; b_sel[1][1:0] = 2'd1; b_dpl[1] = 2'd2; run("R6 conforming high dpl", 0);
        load_good(); pres[1] = 0; run("R6 code absent", 0);
        load_good(); pres[2] = 0; b_dpl[2] = b_dpl[2] + 2'd1; run("R7 stack absent first", 0);
        load_good(); b_typ[2] = 4'b0000; run("R7 stack readonly", 0);
        load_good(); b_typ[4] = 4'b1110; b_dpl[4] = 2'd0; run("R8 conforming data low dpl", 0);
        load_good(); b_typ[5] = 4'b1000; run("R8 execute-only", 0);
        load_good(); b_sel[1][1:0] = 2'd3; b_dpl[1] = 2'd3; b_sel[2][1:0] = 2'd3;
        b_dpl[2] = 2'd3; b_dpl[3] = 2'd2; run("R8 dpl below code rpl", 0);
        load_good(); pres[6] = 0; pres[5] = 0; run("R8 R10 first absent wins", 0);
        load_good(); fok[4] = 0; run("R9 fetch fail", 0);
        load_good(); pres[6] = 0; run("R2 start mid-run", 1);

        for (int i = 0; i < 300; i++) begin
            load_good();
            if ($urandom_range(0, 2) != 0) begin
                int k = $urandom_range(0, N - 1);
                case ($urandom_range(0, 8))
                    0: fok[k] = 0;
                    1: dval[k] = 0;
                    2: cd[k] = ~cd[k];
                    3: b_typ[k] = 4'($urandom);
                    4: b_dpl[k] = 2'($urandom);
                    5: pres[k] = 0;
                    6: b_sel[k] = 16'($urandom_range(0, 3));
                    7: b_sel[k][1:0] = 2'($urandom);
                    default: lim = 20'($urandom_range(0, 12));
                endcase
            end
            run("R3 R10 R11 random", 0);
        end
        summary();
    end
endmodule